// File: doc/BRIEF.md
# Receive Frame Filter and Checker

This block sits behind a serial receive front end. It takes one bit per bit-time strobe, qualified by carrier sense. It hunts through the preamble for the start delimiter and assembles the frame into bytes, sending them straight to a receive FIFO write port. While the first 48 bits arrive, the block decides whether the station wants the frame. A frame is wanted if its destination is the station's own address or the broadcast address, or if it is a group address whose hash bit is set in a 64-entry table. A promiscuous switch accepts every frame.

A running CRC-32, a byte counter and a dribble-bit counter classify the frame when carrier drops. The FIFO has two ways to end a frame: a status strobe, which commits the frame and carries a status word, and a drop strobe, which discards every byte written since the frame began. Short fragments, rejected addresses and frames with no receive buffer are discarded. Error frames are committed only in save-bad mode. Four saturating counters record CRC errors, alignment errors, frames lost for lack of a buffer, and overruns.

Top module: `rx_frame_filter`

## Requirements
- R1: Frame data begins with the bit after the first two consecutive 1 bits seen while carrier is high. Everything before that point is discarded, whatever the length of the preamble.
- R2: A frame is accepted when its 48-bit destination equals `stationAddr` or is all ones. Bits are received least significant bit first, byte 0 of `stationAddr` is bits 7:0, and its bit 0 arrives first.
- R3: A frame whose first received destination bit is 1 is also accepted when `hashTable[idx]` is 1. `idx` is bits 31:26 of the CRC register after the 48 destination bits. The CRC register is 32 bits, preset to all ones, shifted right with feedback polynomial 0xEDB88320, and not inverted.
- R4: With `promisc` high every frame is accepted. A frame that is not accepted produces one `fifoDrop` pulse and no `statWr`.
- R5: Each byte of an accepted frame, including the 4 FCS bytes, is written once to the FIFO with `fifoWr`, assembled LSB first. No write happens in a cycle that follows a cycle with `fifoFull` high.
- R6: A frame of fewer than 64 whole bytes ends with `fifoDrop`, no `statWr`, and no counter change, whatever its CRC.
- R7: A frame with no leftover bits whose CRC register at the end does not hold the residue 0xDEBB20E3 is a CRC error. Such a frame increments `crcErrCnt` and sets status bit 13.
- R8: A frame with 1 to 7 leftover bits is an alignment error (`alignErrCnt`, status bit 14) if the CRC at the last whole byte is wrong. If that CRC is right, the frame is good, with its length in whole bytes.
- R9: A byte that completes while `fifoFull` is high marks the frame overrun, and no later byte of it is written. At the end such a frame increments `overrunCnt` and sets status bit 15, with no CRC or alignment flag.
- R10: An error frame is committed with `statWr` only when `saveBad` is high. Otherwise it ends with `fifoDrop`. Its counter is updated in both cases.
- R11: An accepted frame arriving while `rxReady` is low is dropped at the address decision. It increments `lostCnt` at its end if it reaches 64 bytes.
- R12: Counters reset to zero, saturate at all ones, and clear on `clrCnt`.
- R13: `statWr` or `fifoDrop` pulses in the cycle after the edge that samples carrier low. The two never coincide. The status word is {overrun, alignment, CRC error, good, length[11:0]}, and exactly one of its four flags is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | One-cycle strobe per received bit |
| rxBit | input | 1 | Received data bit, valid with bitEn |
| carrier | input | 1 | Carrier sense, high during a frame |
| stationAddr | input | 48 | Individual address, byte 0 in bits 7:0 |
| hashTable | input | 2**HASH_BITS | Multicast hash enable bits |
| promisc | input | 1 | Accept every frame |
| saveBad | input | 1 | Commit error frames with status |
| rxReady | input | 1 | Receive buffer available |
| fifoFull | input | 1 | FIFO cannot take a byte |
| clrCnt | input | 1 | Clear all statistics counters |
| fifoWr | output | 1 | FIFO byte write strobe |
| fifoData | output | 8 | FIFO byte |
| fifoDrop | output | 1 | Discard the current frame's bytes |
| statWr | output | 1 | Commit frame and write status |
| statWord | output | 16 | Frame status word |
| crcErrCnt | output | CNT_W | CRC error frames |
| alignErrCnt | output | CNT_W | Alignment error frames |
| lostCnt | output | CNT_W | Frames lost for lack of buffer |
| overrunCnt | output | CNT_W | Overrun frames |

## Verification
A byte's FIFO write appears one clock after the edge that samples its eighth bit. The frame verdict (`statWr` or `fifoDrop`) and the counter updates appear one clock after the edge that samples carrier low. The bench logs every output strobe on the falling edge, stamped with a posedge cycle counter. It checks that the status arrives exactly one cycle after the cycle in which carrier was released. Each scenario waits four idle cycles after carrier drops, well past every due cycle, before it compares the logged bytes, verdicts and counters.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int LEN_W = 12;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;

  typedef struct packed {
    logic ovf;
    logic alignErr;
    logic crcErr;
    logic good;
    logic [LEN_W-1:0] len;
  } rxStat_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrFrame;
    logic shiftEn;
    logic wrEn;
    logic incCrc;
    logic incAlign;
    logic incLost;
    logic incOvf;
  } rxCtl_t;

  typedef enum logic [1:0] {ST_HUNT, ST_RECV, ST_SKIP, ST_LOST} rxState_t;

  function automatic logic [31:0] crcStep(input logic [31:0] c, input logic b);
    return (c >> 1) ^ ({32{c[0] ^ b}} & CRC_POLY);
  endfunction
endpackage

// File: rtl/rxf_datapath.sv
module rxf_datapath
  import rxf_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int HASH_BITS = 6
) (
  input  logic clk,
  input  logic rstN,
  input  rxCtl_t ctl,
  input  logic rxBit,
  input  logic fifoFull,
  input  logic [47:0] stationAddr,
  input  logic [(1<<HASH_BITS)-1:0] hashTable,
  input  logic promisc,
  input  logic clrCnt,
  output logic addrLast,
  output logic addrHit,
  output logic [LEN_W-1:0] byteCnt,
  output logic dribble,
  output logic crcOkByte,
  output logic ovfSeen,
  output logic fifoWr,
  output logic [7:0] fifoData,
  output logic [CNT_W-1:0] crcErrCnt,
  output logic [CNT_W-1:0] alignErrCnt,
  output logic [CNT_W-1:0] lostCnt,
  output logic [CNT_W-1:0] overrunCnt
);
  localparam int ADDR_BITS = 48;
  localparam int ACNT_W = $clog2(ADDR_BITS + 1);
  localparam int NUM_CNT = 4;

  logic [31:0] crcReg, crcNext;
  logic [ACNT_W-1:0] addrCnt;
  logic [ADDR_BITS-2:0] destSr;
  logic [ADDR_BITS-1:0] destNext;
  logic [2:0] bitPhase;
  logic [6:0] byteSr;
  logic byteLast;

  assign crcNext  = crcStep(crcReg, rxBit);
  assign destNext = {rxBit, destSr};
  assign addrLast = ctl.shiftEn && (addrCnt == ACNT_W'(ADDR_BITS - 1));
  assign byteLast = ctl.shiftEn && (bitPhase == 3'd7);
  assign dribble  = (bitPhase != 3'd0);

  always_comb begin
    addrHit = promisc || (destNext == stationAddr) || (&destNext);
    if (destNext[0] && hashTable[crcNext[31 -: HASH_BITS]]) addrHit = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg    <= '1;
      addrCnt   <= '0;
      destSr    <= '0;
      bitPhase  <= '0;
      byteSr    <= '0;
      byteCnt   <= '0;
      crcOkByte <= 1'b0;
      ovfSeen   <= 1'b0;
      fifoWr    <= 1'b0;
      fifoData  <= '0;
    end else begin
      fifoWr <= byteLast && ctl.wrEn && !fifoFull && !ovfSeen;
      if (ctl.clrFrame) begin
        crcReg    <= '1;
        addrCnt   <= '0;
        bitPhase  <= '0;
        byteCnt   <= '0;
        crcOkByte <= 1'b0;
        ovfSeen   <= 1'b0;
      end else if (ctl.shiftEn) begin
        crcReg   <= crcNext;
        bitPhase <= bitPhase + 3'd1;
        byteSr   <= {rxBit, byteSr[6:1]};
        if (addrCnt < ACNT_W'(ADDR_BITS)) begin
          addrCnt <= addrCnt + 1'b1;
          destSr  <= destNext[ADDR_BITS-1:1];
        end
        if (byteLast) begin
          fifoData  <= {rxBit, byteSr};
          crcOkByte <= (crcNext == CRC_RESIDUE);
          if (byteCnt != '1) byteCnt <= byteCnt + 1'b1;
          if (ctl.wrEn && fifoFull) ovfSeen <= 1'b1;
        end
      end
    end
  end

  // statistics counters: 0 crc, 1 align, 2 lost, 3 overrun
  logic [NUM_CNT-1:0] incVec;
  logic [CNT_W-1:0] cnt [NUM_CNT];
  assign incVec = {ctl.incOvf, ctl.incLost, ctl.incAlign, ctl.incCrc};

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rstN || clrCnt) cnt[g] <= '0;
      else if (incVec[g] && cnt[g] != '1) cnt[g] <= cnt[g] + 1'b1;
    end
  end

  assign crcErrCnt   = cnt[0];
  assign alignErrCnt = cnt[1];
  assign lostCnt     = cnt[2];
  assign overrunCnt  = cnt[3];
endmodule

// File: rtl/rxf_control.sv
module rxf_control
  import rxf_pkg::*;
#(
  parameter int MIN_BYTES = 64
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitEn,
  input  logic rxBit,
  input  logic carrier,
  input  logic rxReady,
  input  logic saveBad,
  input  logic addrLast,
  input  logic addrHit,
  input  logic [LEN_W-1:0] byteCnt,
  input  logic dribble,
  input  logic crcOkByte,
  input  logic ovfSeen,
  output rxCtl_t ctl,
  output logic statWr,
  output rxStat_t statWord,
  output logic fifoDrop
);
  rxState_t state;
  logic prevOne;
  logic reject, endNow, longEnough;
  logic errOvf, errAlign, errCrc, isErr;

  assign reject     = addrLast && (!addrHit || !rxReady);
  assign endNow     = !carrier && (state == ST_RECV || state == ST_LOST);
  assign longEnough = byteCnt >= LEN_W'(MIN_BYTES);
  assign errOvf     = ovfSeen;
  assign errAlign   = !ovfSeen && dribble && !crcOkByte;
  assign errCrc     = !ovfSeen && !dribble && !crcOkByte;
  assign isErr      = errOvf || errAlign || errCrc;

  always_comb begin
    ctl = '0;
    ctl.clrFrame = (state == ST_HUNT) && carrier && bitEn && rxBit && prevOne;
    ctl.shiftEn  = (state == ST_RECV || state == ST_LOST) && carrier && bitEn;
    ctl.wrEn     = (state == ST_RECV) && !reject;
    if (endNow && longEnough) begin
      if (state == ST_RECV) begin
        ctl.incOvf   = errOvf;
        ctl.incAlign = errAlign;
        ctl.incCrc   = errCrc;
      end else begin
        ctl.incLost = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_HUNT;
      prevOne  <= 1'b0;
      statWr   <= 1'b0;
      statWord <= '0;
      fifoDrop <= 1'b0;
    end else begin
      statWr   <= 1'b0;
      fifoDrop <= 1'b0;
      if (state == ST_HUNT && carrier) begin
        if (bitEn) prevOne <= rxBit;
      end else begin
        prevOne <= 1'b0;
      end
      case (state)
        ST_HUNT: if (ctl.clrFrame) state <= ST_RECV;
        ST_RECV: begin
          if (!carrier) begin
            state <= ST_HUNT;
            if (longEnough && (!isErr || saveBad)) begin
              statWr            <= 1'b1;
              statWord.ovf      <= errOvf;
              statWord.alignErr <= errAlign;
              statWord.crcErr   <= errCrc;
              statWord.good     <= !isErr;
              statWord.len      <= byteCnt;
            end else begin
              fifoDrop <= 1'b1;
            end
          end else if (reject) begin
            fifoDrop <= 1'b1;
            state    <= addrHit ? ST_LOST : ST_SKIP;
          end
        end
        ST_SKIP, ST_LOST: if (!carrier) state <= ST_HUNT;
        default: state <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter
  import rxf_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int HASH_BITS = 6,
  parameter int MIN_BYTES = 64
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitEn,
  input  logic rxBit,
  input  logic carrier,
  input  logic [47:0] stationAddr,
  input  logic [(1<<HASH_BITS)-1:0] hashTable,
  input  logic promisc,
  input  logic saveBad,
  input  logic rxReady,
  input  logic fifoFull,
  input  logic clrCnt,
  output logic fifoWr,
  output logic [7:0] fifoData,
  output logic fifoDrop,
  output logic statWr,
  output logic [15:0] statWord,
  output logic [CNT_W-1:0] crcErrCnt,
  output logic [CNT_W-1:0] alignErrCnt,
  output logic [CNT_W-1:0] lostCnt,
  output logic [CNT_W-1:0] overrunCnt
);
  rxCtl_t ctl;
  rxStat_t statS;
  logic addrLast, addrHit, dribble, crcOkByte, ovfSeen;
  logic [LEN_W-1:0] byteCnt;

  rxf_datapath #(.CNT_W(CNT_W), .HASH_BITS(HASH_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rxBit(rxBit), .fifoFull(fifoFull),
    .stationAddr(stationAddr), .hashTable(hashTable), .promisc(promisc),
    .clrCnt(clrCnt), .addrLast(addrLast), .addrHit(addrHit), .byteCnt(byteCnt),
    .dribble(dribble), .crcOkByte(crcOkByte), .ovfSeen(ovfSeen),
    .fifoWr(fifoWr), .fifoData(fifoData), .crcErrCnt(crcErrCnt),
    .alignErrCnt(alignErrCnt), .lostCnt(lostCnt), .overrunCnt(overrunCnt)
  );

  rxf_control #(.MIN_BYTES(MIN_BYTES)) u_ctl (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .rxBit(rxBit), .carrier(carrier),
    .rxReady(rxReady), .saveBad(saveBad), .addrLast(addrLast), .addrHit(addrHit),
    .byteCnt(byteCnt), .dribble(dribble), .crcOkByte(crcOkByte), .ovfSeen(ovfSeen),
    .ctl(ctl), .statWr(statWr), .statWord(statS), .fifoDrop(fifoDrop)
  );

  assign statWord = statS;
endmodule

// File: rtl/rx_frame_filter_chk.sv
module rx_frame_filter_chk #(
  parameter int CNT_W = 16,
  parameter int MIN_BYTES = 64
) (
  input logic clk,
  input logic rstN,
  input logic saveBad,
  input logic fifoFull,
  input logic clrCnt,
  input logic fifoWr,
  input logic fifoDrop,
  input logic statWr,
  input logic [15:0] statWord,
  input logic [CNT_W-1:0] crcErrCnt,
  input logic [CNT_W-1:0] alignErrCnt,
  input logic [CNT_W-1:0] lostCnt,
  input logic [CNT_W-1:0] overrunCnt
);
  // R13
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(statWr && fifoDrop));

  // R13
  flag_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    statWr |-> $onehot(statWord[15:12]));

  // R6
  min_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    statWr |-> (statWord[11:0] >= 12'(MIN_BYTES)));

  // R10
  bad_needs_save_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && !statWord[12]) |-> $past(saveBad));

  // R5
  no_write_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoWr |-> !$past(fifoFull));

  // R4
  write_drop_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoWr && fifoDrop));

  // R12
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrCnt |=> (crcErrCnt == '0 && alignErrCnt == '0 && lostCnt == '0 && overrunCnt == '0));

  // R12
  cnt_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clrCnt |=> (crcErrCnt >= $past(crcErrCnt) && alignErrCnt >= $past(alignErrCnt) &&
                 lostCnt >= $past(lostCnt) && overrunCnt >= $past(overrunCnt)));
endmodule

bind rx_frame_filter rx_frame_filter_chk #(.CNT_W(CNT_W), .MIN_BYTES(MIN_BYTES)) u_chk (
  .clk(clk), .rstN(rstN), .saveBad(saveBad), .fifoFull(fifoFull), .clrCnt(clrCnt),
  .fifoWr(fifoWr), .fifoDrop(fifoDrop), .statWr(statWr), .statWord(statWord),
  .crcErrCnt(crcErrCnt), .alignErrCnt(alignErrCnt), .lostCnt(lostCnt),
  .overrunCnt(overrunCnt)
);

// File: tb/sim_rx_frame_filter.sv
module sim_rx_frame_filter;
  localparam int CW = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, bitEn, rxBit, carrier, promisc, saveBad, rxReady, fifoFull, clrCnt;
  logic [47:0] stationAddr;
  logic [63:0] hashTable;
  logic fifoWr, fifoDrop, statWr;
  logic [7:0] fifoData;
  logic [15:0] statWord;
  logic [CW-1:0] crcErrCnt, alignErrCnt, lostCnt, overrunCnt;

  rx_frame_filter #(.CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .rxBit(rxBit), .carrier(carrier),
    .stationAddr(stationAddr), .hashTable(hashTable), .promisc(promisc),
    .saveBad(saveBad), .rxReady(rxReady), .fifoFull(fifoFull), .clrCnt(clrCnt),
    .fifoWr(fifoWr), .fifoData(fifoData), .fifoDrop(fifoDrop), .statWr(statWr),
    .statWord(statWord), .crcErrCnt(crcErrCnt), .alignErrCnt(alignErrCnt),
    .lostCnt(lostCnt), .overrunCnt(overrunCnt)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int nWr, nDrop, nStat, statCyc, dropCyc;
  logic [15:0] lastStat;
  logic [7:0] frm [128];
  logic [7:0] rcv [128];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (fifoWr) begin
      rcv[nWr[6:0]] = fifoData;
      nWr++;
    end
    if (fifoDrop) nDrop++;
    if (statWr) begin
      nStat++;
      lastStat = statWord;
      statCyc = cyc;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] crcByte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r = c;
    for (int k = 0; k < 8; k++) begin
      if (r[0] ^ b[k]) r = (r >> 1) ^ 32'hEDB88320;
      else r = r >> 1;
    end
    return r;
  endfunction

  function automatic logic [31:0] expStat(input logic o, input logic a, input logic c,
                                          input logic g, input int len);
    return 32'({o, a, c, g, len[11:0]});
  endfunction

  function automatic logic [5:0] hashIdx(input logic [47:0] d);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < 6; i++) c = crcByte(c, d[8*i +: 8]);
    return c[31:26];
  endfunction

  task automatic buildFrame(input int n, input logic [47:0] dest, input logic corrupt);
    logic [31:0] c = 32'hFFFFFFFF;
    logic [31:0] fcs;
    for (int i = 0; i < 6; i++) frm[i] = dest[8*i +: 8];
    for (int i = 6; i < n - 4; i++) frm[i[6:0]] = 8'(i * 7 + 3);
    for (int i = 0; i < n - 4; i++) c = crcByte(c, frm[i[6:0]]);
    fcs = ~c;
    for (int k = 0; k < 4; k++) frm[7'(n - 4 + k)] = fcs[8*k +: 8];
    if (corrupt) frm[7'(n - 1)] = frm[7'(n - 1)] ^ 8'h5A;
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk);
    bitEn = 1'b1;
    rxBit = b;
    @(negedge clk);
    bitEn = 1'b0;
  endtask

  task automatic sendFrame(input int n, input int preBits, input int drib);
    nWr = 0; nDrop = 0; nStat = 0; lastStat = '0; statCyc = -1;
    @(negedge clk);
    carrier = 1'b1;
    for (int i = 0; i < preBits; i++) sendBit(i % 2 == 0);
    sendBit(1'b1);
    sendBit(1'b1);
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++) sendBit(frm[i[6:0]][k[2:0]]);
    for (int k = 0; k < drib; k++) sendBit(1'b1);
    @(negedge clk);
    carrier = 1'b0;
    dropCyc = cyc;
    repeat (4) @(negedge clk);
  endtask

  function automatic int dataMismatch(input int n);
    int m = 0;
    for (int i = 0; i < n; i++) if (rcv[i[6:0]] !== frm[i[6:0]]) m++;
    return m;
  endfunction

  task automatic tReset;
    check("R12 reset crc cnt", 32'(crcErrCnt), 0);
    check("R12 reset lost cnt", 32'(lostCnt), 0);
    check("R13 reset statWr", 32'(statWr), 0);
    check("R5 reset fifoWr", 32'(fifoWr), 0);
  endtask

  task automatic tUnicast;
    buildFrame(64, stationAddr, 1'b0);
    sendFrame(64, 56, 0);
    check("R2 unicast stat", 32'(lastStat), expStat(0, 0, 0, 1, 64));
    check("R5 unicast byte count", nWr, 64);
    check("R5 unicast data", dataMismatch(64), 0);
    check("R13 stat timing", statCyc, dropCyc + 1);
    check("R13 no drop", nDrop, 0);
  endtask

  task automatic tBroadcastShortPre;
    buildFrame(72, 48'hFFFF_FFFF_FFFF, 1'b0);
    sendFrame(72, 4, 0);
    check("R1 R2 short preamble broadcast", 32'(lastStat), expStat(0, 0, 0, 1, 72));
    check("R1 data aligned", dataMismatch(72), 0);
  endtask

  task automatic tMulticast;
    logic [47:0] grp = 48'h0000_5E00_0001;
    hashTable = 64'd1 << hashIdx(grp);
    buildFrame(64, grp, 1'b0);
    sendFrame(64, 56, 0);
    check("R3 hash hit stat", nStat, 1);
    check("R3 hash hit len", 32'(lastStat), expStat(0, 0, 0, 1, 64));
    hashTable = ~(64'd1 << hashIdx(grp));
    sendFrame(64, 56, 0);
    check("R3 hash miss stat", nStat, 0);
    check("R3 hash miss drop", nDrop, 1);
    hashTable = '0;
  endtask

  task automatic tPromisc;
    buildFrame(64, 48'h0A0B_0C0D_0E10, 1'b0);
    sendFrame(64, 56, 0);
    check("R4 mismatch drop", nDrop, 1);
    check("R4 mismatch no stat", nStat, 0);
    promisc = 1'b1;
    sendFrame(64, 56, 0);
    check("R4 promisc accept", 32'(lastStat), expStat(0, 0, 0, 1, 64));
    check("R4 promisc data", dataMismatch(64), 0);
    promisc = 1'b0;
  endtask

  task automatic tFragment;
    saveBad = 1'b1;
    buildFrame(40, stationAddr, 1'b1);
    sendFrame(40, 56, 0);
    check("R6 bad fragment drop", nDrop, 1);
    check("R6 bad fragment no stat", nStat, 0);
    check("R6 fragment crc cnt", 32'(crcErrCnt), 0);
    buildFrame(63, stationAddr, 1'b0);
    sendFrame(63, 56, 0);
    check("R6 63 byte drop", nDrop, 1);
    check("R6 63 byte no stat", nStat, 0);
    saveBad = 1'b0;
  endtask

  task automatic tCrcErr;
    buildFrame(64, stationAddr, 1'b1);
    sendFrame(64, 56, 0);
    check("R10 crc err dropped", nDrop, 1);
    check("R10 crc err no stat", nStat, 0);
    check("R7 crc cnt 1", 32'(crcErrCnt), 1);
    saveBad = 1'b1;
    sendFrame(64, 56, 0);
    check("R7 R10 crc err stat", 32'(lastStat), expStat(0, 0, 1, 0, 64));
    check("R7 crc cnt 2", 32'(crcErrCnt), 2);
    check("R8 align cnt untouched", 32'(alignErrCnt), 0);
    saveBad = 1'b0;
  endtask

  task automatic tDribble;
    buildFrame(64, stationAddr, 1'b1);
    sendFrame(64, 56, 3);
    check("R8 align err drop", nDrop, 1);
    check("R8 align cnt", 32'(alignErrCnt), 1);
    check("R8 crc cnt unchanged", 32'(crcErrCnt), 2);
    buildFrame(64, stationAddr, 1'b0);
    sendFrame(64, 56, 3);
    check("R8 dribble good stat", 32'(lastStat), expStat(0, 0, 0, 1, 64));
    check("R8 dribble good align cnt", 32'(alignErrCnt), 1);
  endtask

  task automatic tOverrun;
    saveBad = 1'b1;
    fifoFull = 1'b1;
    buildFrame(64, stationAddr, 1'b0);
    sendFrame(64, 56, 0);
    fifoFull = 1'b0;
    check("R9 overrun stat", 32'(lastStat), expStat(1, 0, 0, 0, 64));
    check("R9 overrun cnt", 32'(overrunCnt), 1);
    check("R9 no writes", nWr, 0);
    saveBad = 1'b0;
  endtask

  task automatic tLost;
    rxReady = 1'b0;
    buildFrame(64, stationAddr, 1'b0);
    sendFrame(64, 56, 0);
    rxReady = 1'b1;
    check("R11 lost drop", nDrop, 1);
    check("R11 lost no stat", nStat, 0);
    check("R11 lost cnt", 32'(lostCnt), 1);
  endtask

  task automatic tCounters;
    buildFrame(64, stationAddr, 1'b1);
    for (int i = 0; i < 2; i++) sendFrame(64, 56, 0);
    check("R12 crc saturates", 32'(crcErrCnt), 3);
    @(negedge clk);
    clrCnt = 1'b1;
    @(negedge clk);
    clrCnt = 1'b0;
    check("R12 clear crc", 32'(crcErrCnt), 0);
    check("R12 clear align", 32'(alignErrCnt), 0);
    check("R12 clear lost", 32'(lostCnt), 0);
    check("R12 clear overrun", 32'(overrunCnt), 0);
  endtask

  initial begin
    rstN = 1'b0; bitEn = 1'b0; rxBit = 1'b0; carrier = 1'b0;
    promisc = 1'b0; saveBad = 1'b0; rxReady = 1'b1; fifoFull = 1'b0; clrCnt = 1'b0;
    stationAddr = 48'h5544_3322_1102;
    hashTable = '0;
    nWr = 0; nDrop = 0; nStat = 0; statCyc = -1; dropCyc = 0; lastStat = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tUnicast();
    tBroadcastShortPre();
    tMulticast();
    tPromisc();
    tFragment();
    tCrcErr();
    tDribble();
    tOverrun();
    tLost();
    tCounters();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule